// File: doc/BRIEF.md
# Time-Multiplexed Truncated Quotient Multiplier

This block produces the per-slot quotient word of a word-serial modular multiplier: Q = V × P' mod 2^Ω, where Ω = K·W. V arrives one W-bit limb per cycle over the first K cycles of a slot. P' is a constant held in a local register that is written during setup. Because the result is truncated to Ω bits, only the K(K+1)/2 limb products (i, j) with i + j < K are formed. Products whose shifted value crosses bit Ω keep only their low part, and carries out of the top are dropped.

The products are spread over UNITS = ceil(K(K+1)/(2·S_SHORT)) multiply units. S_SHORT is the shortest slot length among the two modes. Each unit follows a fixed per-step program: at step t it computes product number t·UNITS + u. Products are numbered by anti-diagonal d = i + j, with i rising inside a diagonal. Limb n of Q becomes final once every product with i + j ≤ n has been accumulated. It is announced by a one-cycle write strobe, so the next stage can capture it.

A `mode` input chooses the slot length: S_SHORT cycles when 0, S_LONG cycles when 1. A slot enable is honoured only when no slot is running.

Top module: `qword_mulacc`

## Requirements
- R1: After the last limb strobe of a slot, `q_out` equals (V × P') mod 2^(K·W). Limb n of V is v_in[nW+W-1:nW], and limb n of Q is q_out[nW+W-1:nW].
- R2: Let T_n = floor(((n+1)(n+2)/2 − 1) / UNITS). `q_we[n]` is high for exactly the one cycle that follows the edge at slot step T_n, where step 0 is the edge that accepts `slot_en`. With the defaults (K=3, W=8, UNITS=2), `q_we` reads 3'b001, 3'b010 and 3'b100 in the first, second and third cycle after the accepting edge, and 0 otherwise.
- R3: Q limb n on `q_out` is final in the cycle its strobe is high. Limb 0 does not change again until the next accepted enable.
- R4: V limb n is sampled from its field of `v_in` at slot step n only. Every other field of `v_in` at that step, and any value at other times, has no effect on the result.
- R5: `slot_en` is accepted only when no slot is running. A slot lasts S_SHORT cycles (3) with `mode`=0 and S_LONG cycles (4) with `mode`=1, with the mode taken at acceptance. An enable during a running slot is ignored: no strobe follows it and `q_out` is unchanged.
- R6: `pq_set` writes `pq_data` into the P' register only when no slot is running and no slot is being accepted. A strobe during a slot is ignored, and later slots still use the old P'.
- R7: After reset `q_out` is 0 and `q_we` is 0. While idle, `q_we` stays 0.
- R8: Carries above bit K·W−1 are discarded. For example, V = P' = 2^24−1 gives 1, and 0x800000 × 3 gives 0x800000.
- R9: An enable in the first cycle after a slot ends starts a new slot at once. The accumulation starts again from zero, and nothing of the previous result is added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 1 | Slot length select (0: S_SHORT, 1: S_LONG), sampled on acceptance |
| slot_en | input | 1 | Starts a slot; limb 0 of V is present in the same cycle |
| v_in | input | K*W | V limb bus; limb n read at slot step n |
| pq_set | input | 1 | Load strobe for P' |
| pq_data | input | K*W | New P' value |
| q_out | output | K*W | Quotient word Q, filled limb by limb |
| q_we | output | K | Per-limb one-cycle write strobe |

## Verification
A wrong entry in a unit's step program, or a wrongly bypassed V limb, corrupts Q limb n in the very cycle `q_we[n]` rises. The bench therefore compares each limb at its own strobe rather than only at the end. A step counter that runs too long or too short shows as a strobe in the wrong cycle, or as an enable that is taken or dropped one cycle early, within one slot. A P' register that is not guarded is exposed by the following slot's result.

// File: rtl/qmul_pkg.sv
package qmul_pkg;

   // Diagonal d = i + j of the product with index idx.
   // Products are numbered by diagonal, with row i rising inside a diagonal.
   function automatic int prod_diag(input int idx);
      int rem;
      int res;
      bit found;
      rem   = idx;
      res   = 0;
      found = 1'b0;
      for (int d = 0; d < 64; d++) begin
         if (!found) begin
            if (rem <= d) begin
               res   = d;
               found = 1'b1;
            end else begin
               rem = rem - (d + 1);
            end
         end
      end
      return res;
   endfunction

   // Row i (index of the V limb) of the product with index idx.
   function automatic int prod_row(input int idx);
      int rem;
      int res;
      bit found;
      rem   = idx;
      res   = 0;
      found = 1'b0;
      for (int d = 0; d < 64; d++) begin
         if (!found) begin
            if (rem <= d) begin
               res   = rem;
               found = 1'b1;
            end else begin
               rem = rem - (d + 1);
            end
         end
      end
      return res;
   endfunction

   // Every product must read a V limb that has already arrived by its step.
   function automatic bit sched_ok(input int k, input int units);
      bit ok;
      ok = 1'b1;
      for (int idx = 0; idx < k * (k + 1) / 2; idx++) begin
         if (prod_row(idx) > idx / units) ok = 1'b0;
      end
      return ok;
   endfunction

endpackage

// File: rtl/qmul_seq.sv
module qmul_seq #(
   parameter int S_SHORT = 3,
   parameter int S_LONG  = 4,
   parameter int STEP_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode,
   input  logic              slot_en,
   output logic              accept,
   output logic              busy,
   output logic              active,
   output logic [STEP_W-1:0] step
);

   logic              running_q;
   logic [STEP_W-1:0] step_q;
   logic [STEP_W-1:0] len_q;
   logic [STEP_W-1:0] len;

   assign accept = slot_en & ~running_q;
   assign active = accept | running_q;
   assign busy   = running_q;
   assign step   = accept ? '0 : step_q;
   assign len    = accept ? (mode ? STEP_W'(S_LONG) : STEP_W'(S_SHORT)) : len_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         step_q    <= '0;
         len_q     <= STEP_W'(S_SHORT);
      end else if (active) begin
         step_q    <= step + 1'b1;
         running_q <= (step != STEP_W'(len - 1'b1));
         if (accept) len_q <= len;
      end
   end

endmodule

// File: rtl/qmul_opnd.sv
module qmul_opnd #(
   parameter int W      = 8,
   parameter int K      = 3,
   parameter int STEP_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [STEP_W-1:0] step,
   input  logic [K*W-1:0]    v_in,
   input  logic              pq_set,
   input  logic [K*W-1:0]    pq_data,
   output logic [K*W-1:0]    v_eff,
   output logic [K*W-1:0]    p_store
);

   logic [K*W-1:0] v_q;

   for (genvar n = 0; n < K; n++) begin : g_limb
      logic here;
      assign here = active && (step == STEP_W'(n));
      // A limb is read straight from the bus in its arrival step, then from storage.
      assign v_eff[n*W +: W] = here ? v_in[n*W +: W] : v_q[n*W +: W];
      always_ff @(posedge clk) begin
         if (!rst_n)    v_q[n*W +: W] <= '0;
         else if (here) v_q[n*W +: W] <= v_in[n*W +: W];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 p_store <= '0;
      else if (pq_set && !active) p_store <= pq_data;
   end

endmodule

// File: rtl/qmul_mac.sv
module qmul_mac #(
   parameter int W     = 8,
   parameter int OMEGA = 24,
   parameter int SH_W  = 2
) (
   input  logic [W-1:0]     a,
   input  logic [W-1:0]     b,
   input  logic [SH_W-1:0]  sh,
   input  logic             ok,
   output logic [OMEGA-1:0] term
);

   logic [OMEGA-1:0] prod;

   // Full product fits in OMEGA since OMEGA >= 2W; the shift drops bits above OMEGA.
   assign prod = {{(OMEGA-W){1'b0}}, a} * {{(OMEGA-W){1'b0}}, b};
   assign term = ok ? (prod << (32'(sh) * W)) : '0;

endmodule

// File: rtl/qword_mulacc.sv
module qword_mulacc #(
   parameter int W       = 8,
   parameter int K       = 3,
   parameter int S_SHORT = 3,
   parameter int S_LONG  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mode,
   input  logic           slot_en,
   input  logic [K*W-1:0] v_in,
   input  logic           pq_set,
   input  logic [K*W-1:0] pq_data,
   output logic [K*W-1:0] q_out,
   output logic [K-1:0]   q_we
);

   localparam int OMEGA  = K * W;
   localparam int NPROD  = K * (K + 1) / 2;
   localparam int UNITS  = (NPROD + S_SHORT - 1) / S_SHORT;
   localparam int STEP_W = $clog2(S_LONG + 1);
   localparam int SH_W   = $clog2(K);

   if (K < 2)              begin : g_bad_k   $error("K must be at least 2");          end
   if (W < 1)              begin : g_bad_w   $error("W must be positive");            end
   if (S_SHORT < 2)        begin : g_bad_s   $error("S_SHORT must be at least 2");    end
   if (S_LONG < S_SHORT)   begin : g_bad_l   $error("S_LONG below S_SHORT");          end
   if (!qmul_pkg::sched_ok(K, UNITS)) begin : g_bad_sched
      $error("schedule reads a V limb before it arrives");
   end

   logic              slot_accept;
   logic              slot_busy;
   logic              slot_active;
   logic [STEP_W-1:0] step;
   logic [OMEGA-1:0]  v_eff;
   logic [OMEGA-1:0]  p_store;
   logic [OMEGA-1:0]  terms [UNITS];
   logic [OMEGA-1:0]  sum;
   logic [OMEGA-1:0]  acc_q;
   logic [K-1:0]      we_d;

   qmul_seq #(.S_SHORT(S_SHORT), .S_LONG(S_LONG), .STEP_W(STEP_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .mode(mode), .slot_en(slot_en),
      .accept(slot_accept), .busy(slot_busy), .active(slot_active), .step(step)
   );

   qmul_opnd #(.W(W), .K(K), .STEP_W(STEP_W)) u_opnd (
      .clk(clk), .rst_n(rst_n), .active(slot_active), .step(step),
      .v_in(v_in), .pq_set(pq_set), .pq_data(pq_data),
      .v_eff(v_eff), .p_store(p_store)
   );

   // Per-unit step program: at step t, unit u forms product t*UNITS+u.
   for (genvar u = 0; u < UNITS; u++) begin : g_unit
      logic [W-1:0]    a_s  [S_SHORT];
      logic [W-1:0]    b_s  [S_SHORT];
      logic [SH_W-1:0] sh_s [S_SHORT];
      logic            ok_s [S_SHORT];
      logic [W-1:0]    a;
      logic [W-1:0]    b;
      logic [SH_W-1:0] sh;
      logic            ok;

      for (genvar t = 0; t < S_SHORT; t++) begin : g_op
         localparam int IDX = t * UNITS + u;
         localparam bit OK  = (IDX < NPROD);
         localparam int RI  = OK ? qmul_pkg::prod_row(IDX) : 0;
         localparam int DI  = OK ? qmul_pkg::prod_diag(IDX) : 0;
         localparam int CJ  = DI - RI;
         assign a_s[t]  = v_eff[RI*W +: W];
         assign b_s[t]  = p_store[CJ*W +: W];
         assign sh_s[t] = SH_W'(DI);
         assign ok_s[t] = OK;
      end

      always_comb begin
         a  = '0;
         b  = '0;
         sh = '0;
         ok = 1'b0;
         for (int t = 0; t < S_SHORT; t++) begin
            if (slot_active && (step == STEP_W'(t))) begin
               a  = a_s[t];
               b  = b_s[t];
               sh = sh_s[t];
               ok = ok_s[t];
            end
         end
      end

      qmul_mac #(.W(W), .OMEGA(OMEGA), .SH_W(SH_W)) u_mac (
         .a(a), .b(b), .sh(sh), .ok(ok), .term(terms[u])
      );
   end

   always_comb begin
      sum = '0;
      for (int u = 0; u < UNITS; u++) sum = sum + terms[u];
   end

   // Limb n is final after the step holding the last product of diagonal n.
   for (genvar n = 0; n < K; n++) begin : g_we
      localparam int LAST = (n + 1) * (n + 2) / 2 - 1;
      localparam int TN   = LAST / UNITS;
      assign we_d[n] = slot_active && (step == STEP_W'(TN));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         q_we  <= '0;
      end else begin
         q_we <= we_d;
         if (slot_active) acc_q <= (slot_accept ? '0 : acc_q) + sum;
      end
   end

   assign q_out = acc_q;

endmodule

// File: rtl/qmul_chk.sv
module qmul_chk #(
   parameter int W     = 8,
   parameter int K     = 3,
   parameter int OMEGA = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slot_en,
   input logic             pq_set,
   input logic             accept,
   input logic             busy,
   input logic [W-1:0]     q_lo,
   input logic [K-1:0]     q_we,
   input logic [OMEGA-1:0] p_store
);

   // R2
   first_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> q_we[0]);

   // R3
   low_limb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(q_lo));

   // R5
   ignored_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && slot_en) |=> !q_we[0]);

   // R6
   pq_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((busy || accept) && pq_set) |=> $stable(p_store));

   // R7
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !accept) |=> (q_we == '0));

endmodule

bind qword_mulacc qmul_chk #(.W(W), .K(K), .OMEGA(OMEGA)) u_chk (
   .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .pq_set(pq_set),
   .accept(slot_accept), .busy(slot_busy), .q_lo(q_out[W-1:0]),
   .q_we(q_we), .p_store(p_store)
);

// File: tb/sim_qword_mulacc.sv
module sim_qword_mulacc;

   localparam int W = 8;
   localparam int K = 3;
   localparam int N = 6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          mode;
   logic          slot_en;
   logic [23:0]   v_in;
   logic          pq_set;
   logic [23:0]   pq_data;
   logic [23:0]   q_out;
   logic [2:0]    q_we;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   // {mode, V, P'}
   localparam logic [48:0] VEC [N] = '{
      {1'b0, 24'h000001, 24'h000001},
      {1'b0, 24'h000000, 24'hABCDEF},
      {1'b1, 24'hFFFFFF, 24'hFFFFFF},
      {1'b0, 24'h123456, 24'h00FF01},
      {1'b1, 24'h800000, 24'h000003},
      {1'b0, 24'h00A5C3, 24'h7E0D19}
   };

   always #10 clk = ~clk;

   qword_mulacc #(.W(W), .K(K), .S_SHORT(3), .S_LONG(4)) u0 (
      .clk(clk), .rst_n(rst_n), .mode(mode), .slot_en(slot_en), .v_in(v_in),
      .pq_set(pq_set), .pq_data(pq_data), .q_out(q_out), .q_we(q_we)
   );

   function automatic logic [23:0] ref_q(input logic [23:0] v, input logic [23:0] p);
      logic [47:0] full;
      full = {24'h0, v} * {24'h0, p};
      return full[23:0];
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Bus with limb t carrying V and junk elsewhere (R4).
   function automatic logic [23:0] bus(input logic [23:0] v, input int t);
      logic [23:0] m;
      m = 24'hFF << (8 * t);
      return ((24'h5AC3E7 ^ v ^ 24'h3C3C3C) & ~m) | (v & m);
   endfunction

   task automatic load_p(input logic [23:0] p);
      pq_set = 1'b1; pq_data = p;
      @(negedge clk);
      pq_set = 1'b0; pq_data = ~p;
   endtask

   task automatic run_slot(input logic [23:0] v, input bit m, input logic [23:0] e,
                           input bit poke);
      slot_en = 1'b1; mode = m; v_in = bus(v, 0);
      @(negedge clk);
      slot_en = 1'b0; mode = ~m;
      chk(q_we == 3'b001, "R2 strobe0", 32'(q_we), 32'h1);
      chk(q_out[7:0] == e[7:0], "R3 limb0", 32'(q_out[7:0]), 32'(e[7:0]));
      v_in = bus(v, 1);
      if (poke) begin pq_set = 1'b1; pq_data = 24'hDEAD01; end
      @(negedge clk);
      pq_set = 1'b0;
      chk(q_we == 3'b010, "R2 strobe1", 32'(q_we), 32'h2);
      chk(q_out[15:0] == e[15:0], "R3 limb1", 32'(q_out[15:0]), 32'(e[15:0]));
      v_in = bus(v, 2);
      @(negedge clk);
      v_in = 24'hC0FFEE;
      chk(q_we == 3'b100, "R2 strobe2", 32'(q_we), 32'h4);
      chk(q_out == e, "R1 R8 full", 32'(q_out), 32'(e));
      if (m) begin
         // Step 3 of a long slot: enable must be ignored (R5).
         slot_en = 1'b1; v_in = 24'h777777;
         @(negedge clk);
         slot_en = 1'b0;
         chk(q_we == 3'b000, "R5 ignored enable strobe", 32'(q_we), 32'h0);
         chk(q_out == e, "R5 ignored enable result", 32'(q_out), 32'(e));
      end
   endtask

   initial begin
      rst_n = 1'b0; mode = 1'b0; slot_en = 1'b0; v_in = '0; pq_set = 1'b0; pq_data = '0;
      repeat (3) @(negedge clk);
      chk(q_out == 24'h0, "R7 reset q_out", 32'(q_out), 32'h0);
      chk(q_we == 3'b000, "R7 reset q_we", 32'(q_we), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(q_we == 3'b000, "R7 idle q_we", 32'(q_we), 32'h0);

      for (int i = 0; i < N; i++) begin
         load_p(VEC[i][23:0]);
         run_slot(VEC[i][47:24], VEC[i][48], ref_q(VEC[i][47:24], VEC[i][23:0]), 1'b0);
      end

      // R6: a load strobe during a slot is ignored; the next slot keeps the old P'.
      load_p(24'h135799);
      run_slot(24'h2468AC, 1'b0, ref_q(24'h2468AC, 24'h135799), 1'b1);
      // R9: back-to-back slot right after a short slot, starting from zero.
      run_slot(24'h000102, 1'b0, ref_q(24'h000102, 24'h135799), 1'b0);
      // R5: mode 1 slot followed by a new slot one cycle after its end.
      run_slot(24'hFEDCBA, 1'b1, ref_q(24'hFEDCBA, 24'h135799), 1'b0);
      run_slot(24'h0000FF, 1'b0, ref_q(24'h0000FF, 24'h135799), 1'b0);

      @(negedge clk);
      chk(q_we == 3'b000, "R7 idle after slots", 32'(q_we), 32'h0);
      chk(q_out == ref_q(24'h0000FF, 24'h135799), "R3 hold while idle",
          32'(q_out), 32'(ref_q(24'h0000FF, 24'h135799)));

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

endmodule